// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Fence

This block is a per-core store queue placed between a processor's load/store port and the write port of a coherent shared memory. Stores from the core are accepted into a first-in first-out queue and are written to memory strictly in the order they arrived, one entry per accepted memory write. Until an entry has been accepted by the memory port, no other agent can see it.

Loads are not held behind queued stores. A load first searches the queue for its address. If one or more entries match, the data of the most recently queued matching entry is returned at once and memory is not read. If nothing matches, the load goes straight to the memory read port and may complete while older stores to other addresses are still queued. Only write-to-read order is relaxed; write-to-write order is kept. A fence request stops younger loads until every queued store has been written out, and a one-cycle completion pulse marks the moment the fence is satisfied.

Top module: `tso_store_buf`

## Requirements
- R1: A store is accepted (st_valid and st_ready both high) only while fewer than DEPTH entries are queued; with DEPTH entries queued st_ready is low.
- R2: While the queue is not empty, mw_valid is high and mw_addr/mw_data present the oldest queued store; it is removed only in a cycle with mw_ready high, and stores leave in the order they were accepted.
- R3: A load whose address matches queued entries is answered in the same cycle with ld_fwd high and the data of the youngest matching entry, with mrd_valid low.
- R4: A load with no matching entry raises mrd_valid with its address, completes (ld_ready high) in the cycle mrd_ready is high, and returns mrd_rdata with ld_fwd low, even while older stores to other addresses remain queued.
- R5: Every accepted store is eventually written to memory; after the queue drains, memory holds, for each address, the last value stored to it in program order.
- R6: From the cycle fence_req is seen until fence_done, loads are not accepted; fence_done pulses for one cycle in the first cycle where the queue is empty and no store is being accepted, and the fence is then cleared.
- R7: Synchronous active-low reset empties the queue and clears a pending fence.
- R8: A store accepted in the same cycle as a load to the same address is not forwarded to that load; it becomes visible to loads from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Core store request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Queue can take a store |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | AW | Load address |
| ld_ready | output | 1 | Load completes this cycle |
| ld_fwd | output | 1 | Load data came from the queue |
| ld_data | output | DW | Load result |
| fence_req | input | 1 | Fence request pulse |
| fence_done | output | 1 | Fence satisfied pulse |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mw_ready | input | 1 | Memory accepts the write |
| mrd_valid | output | 1 | Memory read request |
| mrd_addr | output | AW | Memory read address |
| mrd_ready | input | 1 | Memory read completes this cycle |
| mrd_rdata | input | DW | Memory read data |

## Verification
The hardest situation to reach is a load whose address matches several queued entries while the queue wraps around its storage and the head is being popped in the same cycle, since the youngest match then sits at a lower slot index than older ones. The random phase uses only eight addresses, throttles mw_ready so the queue stays deep and wraps often, and mixes loads into every cycle; directed cases add repeated stores to one address, a fence held open by a stalled memory port, a same-cycle store and load, and a reset with a fence pending.

// File: rtl/tsb_pkg.sv
// Package: shared defaults for the store buffer.
// Assumes DEPTH is a power of two so slot pointers wrap naturally.
package tsb_pkg;
    parameter int unsigned TSB_AW    = 8;
    parameter int unsigned TSB_DW    = 32;
    parameter int unsigned TSB_DEPTH = 8;
endpackage

// File: rtl/tsb_queue.sv
// Module: circular store queue holding address/data pairs in arrival order.
// Assumes push is never asserted when full and pop never when empty.
module tsb_queue #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [PW-1:0] head_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] slot_addr [DEPTH],
    output logic [DW-1:0] slot_data [DEPTH]
);
    logic [PW-1:0] tail_ptr;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) tail_ptr <= tail_ptr + 1'b1;
            if (pop)  head_ptr <= head_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Slot storage written at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail_ptr] <= push_addr;
            slot_data[tail_ptr] <= push_data;
        end
    end

    // Status and head view.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        head_addr = slot_addr[head_ptr];
        head_data = slot_data[head_ptr];
    end
endmodule

// File: rtl/tsb_fwd.sv
// Module: associative search returning the youngest queued entry matching an address.
// Assumes slot ages are counted from head_ptr and only the first count slots hold data.
module tsb_fwd #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    input  logic [PW-1:0] head_ptr,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    logic [DEPTH-1:0] match_by_age;

    // Per-age match flags; age 0 is the oldest entry.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW-1:0] slot;
        assign slot            = head_ptr + PW'(k);
        assign match_by_age[k] = (CW'(k) < count) && (slot_addr[slot] == look_addr);
    end

    // Priority pick: later (younger) ages overwrite earlier ones.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match_by_age[k]) begin
                hit      = 1'b1;
                hit_data = slot_data[head_ptr + PW'(k)];
            end
        end
    end
endmodule

// File: rtl/tsb_fence.sv
// Module: fence tracker holding loads until the store queue has drained.
// Assumes empty reflects the queue at the start of the cycle.
module tsb_fence (
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic queue_empty,
    input  logic enq,
    output logic active,
    output logic done,
    output logic pend
);
    // Fence is live from the request cycle until completion.
    always_comb begin
        active = fence_req | pend;
        done   = active & queue_empty & ~enq;
    end

    // Remember an unfinished fence across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= active & ~done;
    end
endmodule

// File: rtl/tso_store_buf.sv
// Module: per-core total-store-order store buffer with forwarding and fence.
// Assumes the memory read port answers in the cycle it raises mrd_ready.
module tso_store_buf
    import tsb_pkg::*;
#(
    parameter int unsigned AW    = TSB_AW,
    parameter int unsigned DW    = TSB_DW,
    parameter int unsigned DEPTH = TSB_DEPTH,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          ld_fwd,
    output logic [DW-1:0] ld_data,
    input  logic          fence_req,
    output logic          fence_done,
    output logic          mw_valid,
    output logic [AW-1:0] mw_addr,
    output logic [DW-1:0] mw_data,
    input  logic          mw_ready,
    output logic          mrd_valid,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrd_ready,
    input  logic [DW-1:0] mrd_rdata
);
    logic          st_fire, pop, full, empty;
    logic [PW-1:0] head_ptr;
    logic [CW-1:0] count;
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic          hit, fence_active, fence_pend, ld_block;
    logic [DW-1:0] hit_data;

    tsb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(st_fire), .push_addr(st_addr), .push_data(st_data),
        .pop(pop), .head_addr(mw_addr), .head_data(mw_data),
        .head_ptr(head_ptr), .count(count), .full(full), .empty(empty),
        .slot_addr(slot_addr), .slot_data(slot_data)
    );

    tsb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
        .slot_addr(slot_addr), .slot_data(slot_data),
        .head_ptr(head_ptr), .count(count), .look_addr(ld_addr),
        .hit(hit), .hit_data(hit_data)
    );

    tsb_fence u_fence (
        .clk(clk), .rst_n(rst_n), .fence_req(fence_req),
        .queue_empty(empty), .enq(st_fire),
        .active(fence_active), .done(fence_done), .pend(fence_pend)
    );

    // Store side: accept when a slot is free.
    always_comb begin
        st_ready = ~full;
        st_fire  = st_valid & st_ready;
    end

    // Drain side: head goes out, popped on acceptance.
    always_comb begin
        mw_valid = ~empty;
        pop      = mw_valid & mw_ready;
    end

    // Load side: forward on hit, otherwise go to memory unless fenced.
    always_comb begin
        ld_block  = fence_active & ~fence_done;
        mrd_valid = ld_valid & ~ld_block & ~hit;
        mrd_addr  = ld_addr;
        ld_ready  = ld_valid & ~ld_block & (hit | mrd_ready);
        ld_fwd    = hit;
        ld_data   = hit ? hit_data : mrd_rdata;
    end
endmodule

// File: rtl/tsb_checker.sv
// Module: property checker for the store buffer, attached by bind.
// Assumes it observes the top module's ports and two internal status signals.
module tsb_checker #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_ready,
    input logic          ld_ready,
    input logic          fence_done,
    input logic          fence_active,
    input logic          mw_valid,
    input logic          mw_ready,
    input logic [AW-1:0] mw_addr,
    input logic [DW-1:0] mw_data,
    input logic [CW-1:0] count
);
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !st_ready);

    p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    p_fence_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !mw_valid);

    p_fence_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_active && mw_valid) |-> !ld_ready);
endmodule

bind tso_store_buf tsb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ld_ready(ld_ready),
    .fence_done(fence_done), .fence_active(fence_active),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .count(count)
);

// File: tb/tso_store_buf_bench.sv
module tso_store_buf_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, fence_req = 0, mw_ready = 0, mrd_ready = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready, ld_ready, ld_fwd, fence_done, mw_valid, mrd_valid;
    logic [DW-1:0] ld_data, mw_data, mrd_rdata;
    logic [AW-1:0] mw_addr, mrd_addr;

    logic [DW-1:0] mem    [256];
    logic [DW-1:0] shadow [256];
    logic [AW-1:0] qa [$];
    logic [DW-1:0] qd [$];
    bit   m_pend = 0;
    int   checks = 0, errors = 0;
    bit   finished = 0;

    always #2 clk = ~clk;
    assign mrd_rdata = mem[ld_addr];

    tso_store_buf u_tso_store_buf (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_ready(ld_ready), .ld_fwd(ld_fwd), .ld_data(ld_data),
        .fence_req(fence_req), .fence_done(fence_done), .mw_valid(mw_valid),
        .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
        .mrd_valid(mrd_valid), .mrd_addr(mrd_addr), .mrd_ready(mrd_ready),
        .mrd_rdata(mrd_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Youngest queued match in the model.
    function automatic bit model_hit(input logic [AW-1:0] a, output logic [DW-1:0] d);
        model_hit = 0; d = '0;
        for (int i = 0; i < qa.size(); i++)
            if (qa[i] == a) begin model_hit = 1; d = qd[i]; end
    endfunction

    task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input bit lv, input logic [AW-1:0] la, input bit fr,
                        input bit mwr, input bit mrr);
        bit exp_str, exp_act, exp_done, exp_lrdy, h;
        logic [DW-1:0] hd;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; ld_valid = lv; ld_addr = la;
        fence_req = fr; mw_ready = mwr; mrd_ready = mrr;
        #1;
        exp_str  = qa.size() < DEPTH;
        exp_act  = fr | m_pend;
        exp_done = exp_act && qa.size() == 0 && !(sv && exp_str);
        check(st_ready == exp_str, "R1 st_ready", st_ready, exp_str);
        check(mw_valid == (qa.size() > 0), "R2 mw_valid", mw_valid, qa.size() > 0);
        if (qa.size() > 0) begin
            check(mw_addr == qa[0], "R2 mw_addr order", mw_addr, qa[0]);
            check(mw_data == qd[0], "R2 mw_data order", mw_data, qd[0]);
        end
        check(fence_done == exp_done, "R6 fence_done", fence_done, exp_done);
        if (lv) begin
            h = model_hit(la, hd);
            exp_lrdy = !(exp_act && !exp_done) && (h || mrr);
            check(ld_ready == exp_lrdy, exp_act ? "R6 load stall" : "R4 ld_ready", ld_ready, exp_lrdy);
            if (!(exp_act && !exp_done)) begin
                check(mrd_valid == !h, h ? "R3 no mem read" : "R4 mrd_valid", mrd_valid, !h);
                check(ld_fwd == h, "R3 ld_fwd", ld_fwd, h);
                if (exp_lrdy && h)  check(ld_data == hd, "R3 youngest data", ld_data, hd);
                if (exp_lrdy && !h) check(ld_data == mem[la], "R4 memory data", ld_data, mem[la]);
            end else
                check(mrd_valid == 0, "R6 no read while fenced", mrd_valid, 0);
        end
        // Advance model to post-edge state.
        if (mwr && qa.size() > 0) begin
            mem[qa[0]] = qd[0];
            void'(qa.pop_front()); void'(qd.pop_front());
        end
        if (sv && exp_str) begin
            qa.push_back(sa); qd.push_back(sd); shadow[sa] = sd;
        end
        m_pend = exp_act && !exp_done;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; st_valid = 0; ld_valid = 0; fence_req = 0; mw_ready = 0; mrd_ready = 0;
        @(negedge clk);
        rst_n = 1;
        qa.delete(); qd.delete(); m_pend = 0;
        for (int i = 0; i < 256; i++) shadow[i] = mem[i];
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 32'h1000 + i * 7; shadow[i] = mem[i]; end
        do_reset();
        // R7: reset state.
        #1;
        check(mw_valid == 0, "R7 empty after reset", mw_valid, 0);
        check(st_ready == 1, "R7 ready after reset", st_ready, 1);
        check(fence_done == 0, "R7 no fence after reset", fence_done, 0);

        // R1: fill to full with memory stalled, same address repeated for R3.
        for (int i = 0; i < DEPTH; i++) step(1, (i % 2) ? 8'd3 : 8'd9, 32'hA000 + i, 0, 0, 0, 0, 0);
        step(1, 8'd4, 32'hBEEF, 1, 8'd3, 0, 0, 0);   // full: store refused, load hits youngest addr 3
        check(qa.size() == DEPTH, "R1 full held", qa.size(), DEPTH);
        step(0, 0, 0, 1, 8'd9, 0, 0, 0);             // R3 youngest of four matches
        step(0, 0, 0, 1, 8'd50, 0, 0, 1);            // R4 miss completes with stores queued
        // R6: fence with memory stalled blocks loads.
        step(0, 0, 0, 1, 8'd50, 1, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'd51, 0, 0, 1);
        while (qa.size() > 0) step(0, 0, 0, 1, 8'd52, 0, 1, 1);
        step(0, 0, 0, 1, 8'd52, 0, 0, 1);            // done cycle, load passes
        check(m_pend == 0, "R6 fence cleared", m_pend, 0);
        // R6: fence when empty but store enqueued same cycle waits.
        step(1, 8'd7, 32'h77, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 8'd7, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R8: same-cycle store and load to one address.
        step(1, 8'd20, 32'hC0DE, 1, 8'd20, 0, 0, 1);
        step(0, 0, 0, 1, 8'd20, 0, 0, 1);
        // R7: reset with stores and a fence pending.
        step(1, 8'd21, 32'h55, 0, 0, 1, 0, 0);
        do_reset();
        #1;
        check(mw_valid == 0, "R7 queue emptied", mw_valid, 0);
        step(0, 0, 0, 1, 8'd21, 0, 0, 1);            // load not blocked after reset

        // Random mix.
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 99) < 45, AW'($urandom_range(0, 7)), $urandom,
                 $urandom_range(0, 99) < 60, AW'($urandom_range(0, 7)),
                 $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 35,
                 $urandom_range(0, 99) < 70);
        end
        // R5: drain everything and compare memory with program order.
        while (qa.size() > 0 || m_pend) step(0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        check(mw_valid == 0, "R5 drained", mw_valid, 0);
        for (int i = 0; i < 8; i++) check(mem[i] == shadow[i], "R5 final memory", mem[i], shadow[i]);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule